// File: doc/BRIEF.md
# Speech parameter bit buffer

This block is the staging store between a host and a speech frame parser. The host pushes coded speech data into it one byte at a time. The parser removes small fields of 1 to 6 bits, asking for a new width on each read. The store holds 16 bytes, which is 128 bits. It is a single shift register plus one counter that holds the number of free bit positions. Data enters on the high side, above the bits already held. Bits leave from the low end, and each read shifts the register down so that the unused space always sits on the write side.

Each incoming byte is placed with its bit order reversed. The most significant bit of the byte is therefore the first bit the parser receives. Within one read the oldest bit appears on `rd_data[0]`. The host gets two status signals to pace its writes: a low-water flag and an empty flag. If the host ignores them and writes into a full store, the byte is lost and nothing else changes. If the parser asks for more bits than the store holds, it gets what is there with zeros above it, and a sticky flag records the underflow.

Top module: `lpc_param_buffer`

## Requirements
- R1: When reset is low at a clock edge, or `flush` is high at a clock edge, `free_bits` becomes 128, `buf_empty` and `buf_low` become 1, and `underflow` becomes 0. A flush overrides any write or read presented in the same cycle.
- R2: A byte with `wr_en` high is accepted when `free_bits` is at least 8 before the edge. Accepting a byte uses 8 bit positions.
- R3: A byte written while `free_bits` is below 8 is discarded. Stored data and `free_bits` do not change, apart from the effect of any read in the same cycle.
- R4: Bits leave in arrival order. For each byte the order is bit 7 first and bit 0 last, and earlier bytes leave before later ones. `rd_data[0]` carries the oldest bit of a read, and `rd_data[k]` carries the bit that follows it k positions later.
- R5: `rd_width` gives the field size directly. A value of 1 to 6 asks for that many bits, 0 asks for none, and 7 is treated as 6. `rd_data` bits at and above the effective width are 0, and `rd_data` is 0 whenever `rd_en` is low.
- R6: A read raises `free_bits` by the number of bits it takes. That number is the smaller of the effective width and the number of occupied bits.
- R7: A read that asks for more bits than are occupied returns the occupied bits with zeros above them, leaves the store empty, and sets `underflow`. The flag stays set until reset or flush.
- R8: A write and a read in the same cycle are both carried out. Whether the write is accepted depends on `free_bits` before the edge, and `free_bits` changes by (bits taken − 8) when the write is accepted.
- R9: `buf_empty` is 1 exactly when `free_bits` is 128. `buf_low` is 1 exactly when fewer than 64 bits are occupied, that is, when `free_bits` is above 64.
- R10: `rd_data` is a combinational view of the oldest bits. It is valid in the same cycle that `rd_en` is raised, before the edge that removes those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Synchronous clear of the whole store |
| wr_en | input | 1 | Host byte write strobe |
| wr_byte | input | 8 | Host data byte, MSB is the first bit in the stream |
| rd_en | input | 1 | Parser read strobe |
| rd_width | input | 3 | Number of bits requested (0..7, 7 treated as 6) |
| rd_data | output | 6 | Extracted field, oldest bit in bit 0, zero padded |
| free_bits | output | 8 | Number of free bit positions, 0..128 |
| buf_low | output | 1 | Fewer than 64 bits occupied |
| buf_empty | output | 1 | No bits occupied |
| underflow | output | 1 | Sticky flag set by a read that asked for more bits than were stored |

## Verification
Directed sequences cover several cases. A single known byte is read out in fields of 4 bits to expose a wrong bit order. The store is filled to the brim and a 17th byte is offered, which separates a clean drop from a byte that wraps over stored data. At a full or nearly full store, writes are paired with reads so that a design deciding acceptance after the read would give a different count. A short read is made on an almost empty store to show padding and the sticky flag. Random phases then bias toward writes and then toward reads. This drives the count through both status thresholds and through every width value, including 0, 2 and 7. A bit-queue model in the bench checks every field and every count.

// File: rtl/lpcbuf_pkg.sv
// Package: shared encodings for the speech parameter bit buffer.
// Assumes: nothing beyond the default geometry constants below.
package lpcbuf_pkg;

    localparam int unsigned LB_DEPTH_BYTES = 16;
    localparam int unsigned LB_BYTE_W      = 8;
    localparam int unsigned LB_RD_MAX      = 6;

    // Per-cycle activity on the free-bit counter: {byte accepted, bits taken}
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_DRAIN = 2'b01,
        OP_FILL  = 2'b10,
        OP_BOTH  = 2'b11
    } lb_op_e;

endpackage

// File: rtl/lpcbuf_flip.sv
// Module: reverses the bit order of one data word.
// Assumes: purely combinational, any width of at least one bit.
module lpcbuf_flip #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // one wire per bit, mirrored about the centre
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/lpcbuf_count.sv
// Module: free-bit counter, read sizing, write admission and status.
// Assumes: free_q never exceeds TOTAL_BITS; writes are judged on the
// count before the edge, so a same-cycle read never makes room for them.
module lpcbuf_count
    import lpcbuf_pkg::*;
#(
    parameter int TOTAL_BITS = 128,
    parameter int BYTE_W     = 8,
    parameter int RD_MAX     = 6,
    parameter int RW_W       = 3,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [RW_W-1:0]  rd_width,
    output logic [CNT_W-1:0] free_q,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] weff,
    output logic [CNT_W-1:0] take,
    output logic             wr_ok,
    output logic             low,
    output logic             empty,
    output logic             underflow
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TOTAL_BITS);
    localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(RD_MAX);
    localparam logic [CNT_W-1:0] LOW_CNT  = CNT_W'(TOTAL_BITS / 2);

    logic [CNT_W-1:0] free_d;
    lb_op_e           op;

    // effective request width: zero when idle, clamped to the field maximum
    always_comb begin
        weff = '0;
        if (rd_en) begin
            weff = (CNT_W'(rd_width) > MAX_CNT) ? MAX_CNT : CNT_W'(rd_width);
        end
    end

    assign occ   = FULL_CNT - free_q;
    assign take  = (weff > occ) ? occ : weff;
    assign wr_ok = wr_en && (free_q >= BYTE_CNT);
    assign op    = lb_op_e'({wr_ok, take != '0});

    // next free count from the combination of fill and drain
    always_comb begin
        case (op)
            OP_FILL:  free_d = free_q - BYTE_CNT;
            OP_DRAIN: free_d = free_q + take;
            OP_BOTH:  free_d = free_q + take - BYTE_CNT;
            default:  free_d = free_q;
        endcase
    end

    // free-bit register with reset and clear to the full size
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            free_q <= FULL_CNT;
        end else begin
            free_q <= free_d;
        end
    end

    // sticky record of a read that wanted more than was stored
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            underflow <= 1'b0;
        end else if (rd_en && (weff > occ)) begin
            underflow <= 1'b1;
        end
    end

    assign empty = (free_q == FULL_CNT);
    assign low   = (occ < LOW_CNT);

endmodule

// File: rtl/lpcbuf_store.sv
// Module: 128-bit shift store; drains from bit 0, inserts above the data.
// Assumes: every bit at or above the occupancy is zero (kept by design),
// so zero padding of short reads needs no occupancy mask.
module lpcbuf_store #(
    parameter int TOTAL_BITS = 128,
    parameter int BYTE_W     = 8,
    parameter int RD_MAX     = 6,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_ok,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [CNT_W-1:0]  occ,
    input  logic [CNT_W-1:0]  weff,
    input  logic [CNT_W-1:0]  take,
    output logic [RD_MAX-1:0] rd_data
);

    logic [TOTAL_BITS-1:0] store_q;
    logic [TOTAL_BITS-1:0] drained;
    logic [TOTAL_BITS-1:0] placed;
    logic [TOTAL_BITS-1:0] store_d;
    logic [RD_MAX-1:0]     rd_mask;

    // drop the bits handed to the parser
    assign drained = store_q >> take;
    // new byte lands just above what remains after the drain
    assign placed  = TOTAL_BITS'(byte_in) << (occ - take);

    // merge the accepted byte into the drained image
    always_comb begin
        store_d = drained;
        if (wr_ok) begin
            store_d = drained | placed;
        end
    end

    // store register, cleared on reset and flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    // keep only the requested number of low bits
    for (genvar i = 0; i < RD_MAX; i++) begin : g_mask
        assign rd_mask[i] = (CNT_W'(i) < weff);
    end

    assign rd_data = store_q[RD_MAX-1:0] & rd_mask;

endmodule

// File: rtl/lpc_param_buffer.sv
// Module: top of the speech parameter bit buffer. Byte writes from a host,
// 0..6 bit reads for a frame parser, plus host status flags.
// Assumes: rst_n is synchronous and active low; rd_width 7 means 6.
module lpc_param_buffer #(
    parameter int DEPTH_BYTES = 16,
    parameter int BYTE_W      = 8,
    parameter int RD_MAX      = 6,
    parameter int RW_W        = 3
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      flush,
    input  logic                                      wr_en,
    input  logic [BYTE_W-1:0]                         wr_byte,
    input  logic                                      rd_en,
    input  logic [RW_W-1:0]                           rd_width,
    output logic [RD_MAX-1:0]                         rd_data,
    output logic [$clog2(DEPTH_BYTES*BYTE_W+1)-1:0]   free_bits,
    output logic                                      buf_low,
    output logic                                      buf_empty,
    output logic                                      underflow
);

    localparam int TOTAL_BITS = DEPTH_BYTES * BYTE_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 1);

    logic [BYTE_W-1:0] flipped;
    logic [CNT_W-1:0]  occ;
    logic [CNT_W-1:0]  weff;
    logic [CNT_W-1:0]  take;
    logic              wr_ok;

    // mirror the host byte so its MSB is extracted first
    lpcbuf_flip #(.W(BYTE_W)) u_flip (
        .din  (wr_byte),
        .dout (flipped)
    );

    // counter, admission and flags
    lpcbuf_count #(
        .TOTAL_BITS (TOTAL_BITS),
        .BYTE_W     (BYTE_W),
        .RD_MAX     (RD_MAX),
        .RW_W       (RW_W),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rd_width  (rd_width),
        .free_q    (free_bits),
        .occ       (occ),
        .weff      (weff),
        .take      (take),
        .wr_ok     (wr_ok),
        .low       (buf_low),
        .empty     (buf_empty),
        .underflow (underflow)
    );

    // bit storage
    lpcbuf_store #(
        .TOTAL_BITS (TOTAL_BITS),
        .BYTE_W     (BYTE_W),
        .RD_MAX     (RD_MAX),
        .CNT_W      (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_ok   (wr_ok),
        .byte_in (flipped),
        .occ     (occ),
        .weff    (weff),
        .take    (take),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/lpcbuf_chk.sv
// Module: port-level properties of lpc_param_buffer, bound to every instance.
// Assumes: observes ports only; reset low disables all properties.
module lpcbuf_chk #(
    parameter int DEPTH_BYTES = 16,
    parameter int BYTE_W      = 8,
    parameter int RD_MAX      = 6,
    parameter int RW_W        = 3,
    parameter int CNT_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              wr_en,
    input logic              rd_en,
    input logic [RW_W-1:0]   rd_width,
    input logic [RD_MAX-1:0] rd_data,
    input logic [CNT_W-1:0]  free_bits,
    input logic              buf_low,
    input logic              buf_empty,
    input logic              underflow
);

    localparam int TOTAL = DEPTH_BYTES * BYTE_W;

    int c_req;
    int c_occ;
    int c_take;

    // requested and granted sizes seen from the ports
    always_comb begin
        c_req  = (int'(rd_width) > RD_MAX) ? RD_MAX : int'(rd_width);
        c_occ  = TOTAL - int'(free_bits);
        c_take = (c_req > c_occ) ? c_occ : c_req;
    end

    p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (int'(free_bits) == TOTAL) && !underflow);

    p_accept_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush && int'(free_bits) >= BYTE_W)
        |=> int'(free_bits) == int'($past(free_bits)) - BYTE_W);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush && int'(free_bits) < BYTE_W)
        |=> $stable(free_bits));

    p_pad_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_width) < RD_MAX) |-> ((rd_data >> rd_width) == '0));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    p_drain_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !flush)
        |=> int'(free_bits) == int'($past(free_bits)) + $past(c_take));

    p_underflow_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush && c_req > c_occ) |=> underflow);

    p_underflow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush) |=> underflow);

    p_empty_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty == (int'(free_bits) == TOTAL));

    p_low_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_low == (int'(free_bits) > TOTAL / 2));

    p_empty_pads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && buf_empty) |-> rd_data == '0);

endmodule

bind lpc_param_buffer lpcbuf_chk #(
    .DEPTH_BYTES (DEPTH_BYTES),
    .BYTE_W      (BYTE_W),
    .RD_MAX      (RD_MAX),
    .RW_W        (RW_W),
    .CNT_W       ($clog2(DEPTH_BYTES*BYTE_W+1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_width  (rd_width),
    .rd_data   (rd_data),
    .free_bits (free_bits),
    .buf_low   (buf_low),
    .buf_empty (buf_empty),
    .underflow (underflow)
);

// File: tb/sim_lpc_param_buffer.sv
`timescale 1ns/1ps
// Bench: bit-queue model of the buffer, directed corners then biased random.
module sim_lpc_param_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_en = 1'b0;
    logic [2:0] rd_width = 3'd0;
    logic [5:0] rd_data;
    logic [7:0] free_bits;
    logic       buf_low;
    logic       buf_empty;
    logic       underflow;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  mq[$];
    bit  m_unf = 1'b0;

    always #2 clk = ~clk;

    lpc_param_buffer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .rd_en     (rd_en),
        .rd_width  (rd_width),
        .rd_data   (rd_data),
        .free_bits (free_bits),
        .buf_low   (buf_low),
        .buf_empty (buf_empty),
        .underflow (underflow)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_w(bit r, int w);
        if (!r) return 0;
        return (w > 6) ? 6 : w;
    endfunction

    function automatic int peek(int w);
        int v = 0;
        for (int i = 0; i < w; i++) begin
            if (i < mq.size() && mq[i]) v |= (1 << i);
        end
        return v;
    endfunction

    task automatic state_chk(string tag);
        int fr = 128 - mq.size();
        chk({tag, " R2 R3 R6 R8 free_bits"}, int'(free_bits), fr);
        chk({tag, " R9 buf_empty"}, int'(buf_empty), int'(fr == 128));
        chk({tag, " R9 buf_low"}, int'(buf_low), int'(fr > 64));
        chk({tag, " R7 underflow"}, int'(underflow), int'(m_unf));
    endtask

    // one clock of stimulus with model update and checks
    task automatic step(bit w, logic [7:0] b, bit r, int wd, bit f);
        int we;
        int occ;
        int tk;
        bit acc;
        @(negedge clk);
        wr_en = w; wr_byte = b; rd_en = r; rd_width = 3'(wd); flush = f;
        #1;
        we = eff_w(r, wd);
        chk("R10 R4 R5 rd_data", int'(rd_data), peek(we));
        if (f) begin
            mq.delete();
            m_unf = 1'b0;
        end else begin
            occ = mq.size();
            acc = w && ((128 - occ) >= 8);
            tk  = (we > occ) ? occ : we;
            if (r && we > occ) m_unf = 1'b1;
            for (int k = 0; k < tk; k++) void'(mq.pop_front());
            if (acc) for (int k = 7; k >= 0; k--) mq.push_back(b[k]);
        end
        @(posedge clk);
        #1;
        state_chk(f ? "R1" : "step");
    endtask

    initial begin
        void'($urandom(32'h1F3A_5EED));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        state_chk("R1 reset");

        // R4: a known byte leaves MSB first (0xA5 -> fields 0x5 then 0xA)
        step(1, 8'hA5, 0, 0, 0);
        step(0, 8'h00, 1, 4, 0);
        step(0, 8'h00, 1, 4, 0);

        // R2 R3: fill to the brim, 17th byte dropped
        for (int i = 0; i < 17; i++) step(1, 8'(8'h11 * i + 3), 0, 0, 0);
        chk("R3 full count", int'(free_bits), 0);

        // R8: writes judged before the edge
        step(1, 8'hFF, 1, 6, 0);   // free 0: dropped, free 6
        step(1, 8'hEE, 1, 3, 0);   // free 6: dropped, free 9
        step(1, 8'h5C, 1, 1, 0);   // free 9: accepted, free 2
        chk("R8 net count", int'(free_bits), 2);

        // R5: width 0 and 7
        step(0, 8'h00, 1, 0, 0);
        step(0, 8'h00, 1, 7, 0);
        step(0, 8'h00, 1, 2, 0);

        // R1: flush overrides a write
        step(1, 8'h77, 1, 5, 1);
        chk("R1 flush", int'(free_bits), 128);

        // R7: short read pads and sets the sticky flag
        step(1, 8'hC3, 0, 0, 0);
        step(0, 8'h00, 1, 6, 0);
        step(0, 8'h00, 1, 6, 0);
        step(0, 8'h00, 1, 5, 0);
        step(1, 8'h9A, 0, 0, 0);
        chk("R7 sticky", int'(underflow), 1);
        step(0, 8'h00, 0, 0, 1);

        // random phases: writer-heavy then reader-heavy
        for (int ph = 0; ph < 8; ph++) begin
            for (int c = 0; c < 400; c++) begin
                int pw = (ph % 2 == 0) ? 70 : 25;
                int pr = (ph % 2 == 0) ? 30 : 80;
                int wsel = $urandom_range(0, 9);
                int wd;
                case (wsel)
                    0: wd = 0;
                    1: wd = 2;
                    2: wd = 7;
                    3, 4: wd = 6;
                    5: wd = 5;
                    6: wd = 4;
                    7: wd = 3;
                    default: wd = 1;
                endcase
                step(($urandom_range(0, 99) < pw), 8'($urandom()),
                     ($urandom_range(0, 99) < pr), wd,
                     ($urandom_range(0, 299) == 0));
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule